// File: doc/BRIEF.md
# Run-Length Byte Stream Compressor

This block compresses the outgoing byte stream of a parallel port. It watches for identical consecutive bytes and replaces each such run with two bytes: a command byte that holds the run length, and then one copy of the repeated byte. A byte that stands alone is passed on as a plain data byte, with no command byte ahead of it. Every output byte carries a tag bit that tells the next stage whether it is a command or a data byte. This is the encoding that the matching decompressor on the far side expects.

Input and output are valid/ready byte streams. The `in_last` sideband marks the final byte of a burst. That byte is added to the open run, and the run is then closed and sent. The `enable` input turns compression off. While it is low, bytes go through one-for-one, tagged as data. A run that is still open when `enable` falls is sent first.

Top module: `rle_compressor`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A run of N identical bytes, with 2 <= N <= 128, is sent as a command byte followed by one data byte. The command byte has `out_cmd`=1, bit 7 set and bits 6..0 equal to N-1. The data byte has `out_cmd`=0 and carries the repeated value.
- R3: A run of one byte is sent as that byte alone with `out_cmd`=0, including values of 0x80 and above.
- R4: An accepted byte that differs from the open run closes that run. The run is sent before any byte that follows it, so output order follows input order.
- R5: A run longer than 128 bytes is split. Each full chunk of 128 is sent as command 0xFF plus the byte, and the remainder is encoded by R2 or R3.
- R6: A byte accepted with `in_last`=1 joins the open run, and that run is then sent. A later equal byte starts a new run, and `in_ready` is 0 in the cycle after that accept.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_cmd` hold their values. Input is held off, and no byte is lost or repeated.
- R8: With `enable`=0, each accepted byte appears one cycle later with `out_cmd`=0 and its value unchanged.
- R9: If `enable` is 0 while a run is open, `in_ready` stays 0 until that run has been sent. The run comes out ahead of the pass-through bytes.
- R10: A byte tagged `out_cmd`=1 always has bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | 1 = compress, 0 = pass through |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the burst; flush the run |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_cmd | output | 1 | 1 = run-length command byte, 0 = data byte |

## Verification
The hardest cases to reach are the run-length limit combined with backpressure, and a drop of `enable` while a run is still open. The bench streams runs of 128, 129 and 130 equal bytes while `out_ready` follows a periodic stall pattern. This exercises the split exactly at the count limit, with the queue sometimes full. It also holds `out_ready` low for many cycles in the middle of a stream, which confirms that the first byte holds steady and input is held off. A table entry then opens a run and clears `enable` on the next byte, so the forced flush must come out before the pass-through byte.

// File: rtl/rle_pkg.sv
package rle_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = BYTE_W - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // one entry of the output queue
    typedef struct packed {
        logic  valid;
        logic  cmd;
        byte_t data;
    } slot_t;

    // command byte: marker bit on top, stored count (length-1) below
    function automatic byte_t make_cmd(input cnt_t c);
        return {1'b1, c};
    endfunction

endpackage

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
    import rle_pkg::*;
#(
    parameter int MAX_RUN = 128
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  logic  in_valid,
    input  byte_t in_data,
    input  logic  in_last,
    input  logic  q_empty,
    output logic  in_ready,
    output logic  load,
    output byte_t load_byte,
    output cnt_t  load_cnt
);

    localparam cnt_t CNT_LIMIT = cnt_t'(MAX_RUN - 1);

    logic  run_open;
    byte_t run_byte;
    cnt_t  run_cnt;
    logic  flush_pend;

    logic acc;
    logic flush_now;
    logic extend;

    always_comb begin
        in_ready  = q_empty && !flush_pend && (enable || !run_open);
        acc       = in_valid && in_ready;
        flush_now = q_empty && run_open && (flush_pend || !enable);
        extend    = run_open && (in_data == run_byte) && (run_cnt != CNT_LIMIT);

        load      = 1'b0;
        load_byte = run_byte;
        load_cnt  = run_cnt;
        if (flush_now) begin
            load = 1'b1;
        end else if (acc && !enable) begin
            load      = 1'b1;
            load_byte = in_data;
            load_cnt  = '0;
        end else if (acc && run_open && !extend) begin
            load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_open   <= 1'b0;
            run_byte   <= '0;
            run_cnt    <= '0;
            flush_pend <= 1'b0;
        end else if (flush_now) begin
            run_open   <= 1'b0;
            flush_pend <= 1'b0;
        end else if (acc && enable) begin
            run_open   <= 1'b1;
            flush_pend <= in_last;
            if (extend) begin
                run_cnt <= run_cnt + cnt_t'(1);
            end else begin
                run_byte <= in_data;
                run_cnt  <= '0;
            end
        end
    end

    // R9
    open_blocks_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && run_open) |-> !in_ready);

    // R6
    last_closes_run_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && enable && in_last) |=> !in_ready);

    // R4
    load_into_empty_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> q_empty);

endmodule

// File: rtl/rle_emit_queue.sv
module rle_emit_queue
    import rle_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t load_byte,
    input  cnt_t  load_cnt,
    input  logic  out_ready,
    output logic  out_valid,
    output byte_t out_data,
    output logic  out_cmd,
    output logic  q_empty
);

    slot_t head;
    slot_t tail;

    assign out_valid = head.valid;
    assign out_data  = head.data;
    assign out_cmd   = head.cmd;
    assign q_empty   = !head.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
        end else if (load) begin
            if (load_cnt == '0) begin
                head <= '{valid: 1'b1, cmd: 1'b0, data: load_byte};
                tail <= '0;
            end else begin
                head <= '{valid: 1'b1, cmd: 1'b1, data: make_cmd(load_cnt)};
                tail <= '{valid: 1'b1, cmd: 1'b0, data: load_byte};
            end
        end else if (head.valid && out_ready) begin
            head <= tail;
            tail <= '0;
        end
    end

    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_cmd)));

    // R10
    cmd_marker_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cmd) |-> out_data[BYTE_W-1]);

    // R2
    count_field_chk: assert property (@(posedge clk) disable iff (rst)
        (load && load_cnt != '0) |=> (out_cmd && out_data[CNT_W-1:0] == $past(load_cnt)));

    // R7
    queue_order_chk: assert property (@(posedge clk) disable iff (rst)
        tail.valid |-> head.valid);

endmodule

// File: rtl/rle_compressor.sv
module rle_compressor
    import rle_pkg::*;
#(
    parameter int MAX_RUN = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_cmd
);

    logic  q_empty;
    logic  load;
    byte_t load_byte;
    cnt_t  load_cnt;

    rle_run_tracker #(.MAX_RUN(MAX_RUN)) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .q_empty   (q_empty),
        .in_ready  (in_ready),
        .load      (load),
        .load_byte (load_byte),
        .load_cnt  (load_cnt)
    );

    rle_emit_queue u_queue (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_byte (load_byte),
        .load_cnt  (load_cnt),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_cmd   (out_cmd),
        .q_empty   (q_empty)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !enable) |=>
            (out_valid && !out_cmd && out_data == $past(in_data)));

endmodule

// File: tb/tb_rle_compressor.sv
module tb_rle_compressor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_cmd;

    always #2 clk = ~clk;

    rle_compressor dut (
        .clk(clk), .rst(rst), .enable(enable),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_cmd(out_cmd)
    );

    int total = 0;
    int bad   = 0;

    // stimulus {enable, last, data}
    localparam int NS = 22;
    localparam logic [9:0] STIM [NS] = '{
        10'h2_41, 10'h2_41, 10'h2_41, 10'h3_42,           // R2 run of 3, R6 last
        10'h3_43,                                           // R3 lone byte
        10'h2_44, 10'h2_45, 10'h3_45,                       // R4
        10'h3_46, 10'h3_46,                                 // R6 equal bytes split by last
        10'h3_90,                                           // R3 value >= 0x80
        10'h0_80, 10'h0_80, 10'h0_FF,                       // R8 pass-through
        10'h2_47, 10'h2_47, 10'h0_48,                       // R9 enable drop with open run
        10'h2_49, 10'h2_49, 10'h2_4A, 10'h2_4A, 10'h3_4B    // R4 back-to-back runs
    };
    // expected output {cmd, data}
    localparam int NE = 21;
    localparam logic [8:0] EXPV [NE] = '{
        9'h1_82, 9'h0_41, 9'h0_42,
        9'h0_43,
        9'h0_44, 9'h1_81, 9'h0_45,
        9'h0_46, 9'h0_46,
        9'h0_90,
        9'h0_80, 9'h0_80, 9'h0_FF,
        9'h1_81, 9'h0_47, 9'h0_48,
        9'h1_81, 9'h0_49, 9'h1_81, 9'h0_4A, 9'h0_4B
    };

    logic [8:0] exp_q [0:511];
    string      exp_r [0:511];
    int         wr = 0;
    int         rd = 0;
    int         stall_mode = 0;   // 0 ready, 1 periodic stall, 2 held low
    int         cyc = 0;

    task automatic push(input logic [8:0] v, input string r);
        exp_q[wr] = v;
        exp_r[wr] = r;
        wr++;
    endtask

    task automatic check(input bit ok, input string r, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // output collector
    always @(negedge clk) begin
        cyc++;
        case (stall_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = (cyc % 4) != 3;
            default: out_ready = 1'b0;
        endcase
        #1;
        if (!rst && out_valid && out_ready) begin
            if (rd >= wr) begin
                check(1'b0, "R7 extra output", {out_cmd, out_data}, 0);
            end else begin
                check({out_cmd, out_data} == exp_q[rd], exp_r[rd],
                      {out_cmd, out_data}, exp_q[rd]);
                rd++;
            end
        end
    end

    task automatic send(input logic en, input logic last, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        enable   = en;
        in_last  = last;
        in_data  = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain(input string r);
        for (int i = 0; i < 3000 && rd < wr; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        check(rd == wr, r, rd, wr);
    endtask

    task automatic send_run(input int n, input logic [7:0] d);
        for (int i = 0; i < n; i++) send(1'b1, i == n - 1, d);
    endtask

    task automatic report;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        check(!out_valid && in_ready, "R1 reset state", {out_valid, in_ready}, 2'b01);

        for (int k = 0; k < NE; k++) push(EXPV[k], "R2/R3/R4/R6/R8/R9 table");
        for (int k = 0; k < NS; k++) send(STIM[k][9], STIM[k][8], STIM[k][7:0]);
        drain("R4 table stream count");

        // R5 splits at the limit, under periodic backpressure (R7)
        stall_mode = 1;
        push(9'h1_FF, "R5 run of 128 cmd");
        push(9'h0_55, "R5 run of 128 data");
        send_run(128, 8'h55);
        push(9'h1_FF, "R5 run of 129 cmd");
        push(9'h0_57, "R5 run of 129 data");
        push(9'h0_57, "R5 run of 129 remainder");
        send_run(129, 8'h57);
        push(9'h1_FF, "R5 run of 130 cmd");
        push(9'h0_56, "R5 run of 130 data");
        push(9'h1_81, "R5 run of 130 rest cmd");
        push(9'h0_56, "R5 run of 130 rest data");
        send_run(130, 8'h56);
        drain("R5 split stream count");

        // R7 long stall in the middle of a stream
        stall_mode = 2;
        push(9'h1_81, "R7 stalled cmd");
        push(9'h0_61, "R7 stalled data");
        push(9'h1_81, "R7 second cmd");
        push(9'h0_62, "R7 second data");
        fork
            begin
                send(1'b1, 1'b0, 8'h61);
                send(1'b1, 1'b0, 8'h61);
                send(1'b1, 1'b0, 8'h62);
                send(1'b1, 1'b1, 8'h62);
            end
        join_none
        repeat (20) @(negedge clk);
        #2;
        check(out_valid && out_cmd && out_data == 8'h81, "R7 head held",
              {out_valid, out_cmd, out_data}, 10'h3_81);
        check(!in_ready, "R7 input held off", in_ready, 0);
        stall_mode = 0;
        wait fork;
        drain("R7 no loss after stall");

        report();
    end

endmodule